// File: doc/BRIEF.md
# OC-12 Receive Frame Aligner with Alarm Fill

This block sits on the receive side of a byte-wide OC-12 link, after byte-boundary recovery. It watches the incoming byte stream for the six-byte framing word that spans the join between the A1 and A2 framing bytes. From that word it derives the frame position of every byte. It keeps an out-of-frame flag with asymmetric hysteresis: two consecutive confirmations are needed to declare frame, and four consecutive misses are needed to lose it. While out of frame it fills the channel with an all-ones alarm signal, but it still emits a regenerated A1/A2 framing header, so that later stages can keep their own framing.

Every accepted byte comes out one cycle later. With it come a start-of-frame pulse and the byte's row and column, which the overhead stages downstream use. A static control input turns the alarm fill off, so data passes untouched even while out of frame.

Top module: `oc12_frame_aligner`

## Requirements
- R1: During and directly after reset, `oof` is 1 and `out_valid` and `out_sof` are 0.
- R2: The framing word is three bytes 0xF6 followed by three bytes 0x28. When a match is taken as a new alignment, its last byte is assigned row 0, column A1_CNT+2, which is 6 with A1_CNT=4.
- R3: `oof` falls only when the word is found at the expected place in two consecutive frames. It falls right after the second of those bytes is accepted.
- R4: In frame, `oof` rises only after the word is absent at its expected place in four consecutive frames. A hit at the expected place clears the miss count. A word found at any other place has no effect.
- R5: While `oof` is 1 and `ais_dis` is 0, the output at row 0 is 0xF6 in columns 0..A1_CNT-1 and 0x28 in columns A1_CNT..2*A1_CNT-1, and every other output byte is 0xFF.
- R6: While `ais_dis` is 1, every byte passes unchanged, even while out of frame.
- R7: In frame, each accepted byte appears unchanged on `out_byte` one clock later, with `out_valid` high.
- R8: During confirmation, a match at a place other than the expected one re-anchors the position and restarts confirmation. That frame does not count toward leaving out-of-frame.
- R9: `out_row`/`out_col` give the position of the byte on `out_byte`, and `out_sof` is 1 exactly on the byte at row 0, column 0.
- R10: A cycle with `in_valid` low gives `out_valid` low on the next cycle and does not advance the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Qualifies `in_byte` |
| in_byte | input | 8 | Received byte |
| ais_dis | input | 1 | 1 turns off the all-ones fill while out of frame |
| out_valid | output | 1 | Qualifies the output byte and its position |
| out_byte | output | 8 | Byte delivered downstream |
| out_sof | output | 1 | Marks row 0, column 0 |
| out_row | output | ROW_W | Row of the output byte |
| out_col | output | COL_W | Column of the output byte |
| oof | output | 1 | Out-of-frame status |

## Verification
Each accepted byte reaches `out_byte`, `out_row`, `out_col` and `out_sof` one clock after it enters, and `oof` changes on that same edge. The bench therefore drives a byte on a falling edge and reads all outputs on the next falling edge. Frame-state decisions are read right after the last byte of the framing word in each frame, because that is the only byte that can move `oof`. Idle gaps are checked on the cycle after they occur.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_SYNC    = 2'd2
  } fa_state_e;

  localparam logic [7:0] A1_VAL  = 8'hF6;
  localparam logic [7:0] A2_VAL  = 8'h28;
  localparam logic [7:0] AIS_VAL = 8'hFF;
endpackage

// File: rtl/fa_pattern_det.sv
module fa_pattern_det #(
  parameter int HALF = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] din,
  output logic       hit
);
  import fa_pkg::*;

  localparam int N  = 2 * HALF;
  localparam int HW = (N - 1) * 8;

  logic [HW-1:0]  hist_q;
  logic [HW-1:0]  hist_d;
  logic [N*8-1:0] win;
  logic [N-1:0]   eq;

  assign win = {hist_q, din};

  // byte i = 0 is the oldest in the window
  for (genvar i = 0; i < N; i++) begin : g_cmp
    if (i < HALF) begin : g_a1
      assign eq[i] = (win[(N-1-i)*8 +: 8] == A1_VAL);
    end else begin : g_a2
      assign eq[i] = (win[(N-1-i)*8 +: 8] == A2_VAL);
    end
  end

  assign hit = en & (&eq);

  always_comb begin
    hist_d = hist_q;
    if (en) hist_d = win[HW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/fa_pos_counter.sv
module fa_pos_counter #(
  parameter int ROWS      = 9,
  parameter int COLS      = 1080,
  parameter int ANCHOR    = 14,
  parameter int ROW_W     = 4,
  parameter int COL_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  output logic [ROW_W-1:0] cur_row,
  output logic [COL_W-1:0] cur_col,
  output logic             at_anchor
);
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;

  assign at_anchor = (row_q == '0) && (col_q == COL_W'(ANCHOR));

  always_comb begin
    if (load) begin
      cur_row = '0;
      cur_col = COL_W'(ANCHOR);
    end else begin
      cur_row = row_q;
      cur_col = col_q;
    end
  end

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    if (en) begin
      if (cur_col == COL_W'(COLS - 1)) begin
        col_d = '0;
        row_d = (cur_row == ROW_W'(ROWS - 1)) ? '0 : cur_row + 1'b1;
      end else begin
        col_d = cur_col + 1'b1;
        row_d = cur_row;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end
endmodule

// File: rtl/fa_sync_fsm.sv
module fa_sync_fsm #(
  parameter int MISS_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hit,
  input  logic at_anchor,
  output logic load,
  output logic oof
);
  import fa_pkg::*;

  localparam int MW = $clog2(MISS_LIMIT + 1);

  fa_state_e     st_q, st_d;
  logic [MW-1:0] miss_q, miss_d;

  always_comb begin
    st_d   = st_q;
    miss_d = miss_q;
    load   = 1'b0;
    if (en) begin
      unique case (st_q)
        ST_HUNT: begin
          if (hit) begin
            load = 1'b1;
            st_d = ST_CONFIRM;
          end
        end
        ST_CONFIRM: begin
          if (at_anchor) begin
            st_d   = hit ? ST_SYNC : ST_HUNT;
            miss_d = '0;
          end else if (hit) begin
            load = 1'b1;
          end
        end
        ST_SYNC: begin
          if (at_anchor) begin
            if (hit) begin
              miss_d = '0;
            end else if (miss_q == MW'(MISS_LIMIT - 1)) begin
              miss_d = '0;
              st_d   = ST_HUNT;
            end else begin
              miss_d = miss_q + 1'b1;
            end
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  assign oof = (st_q != ST_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      miss_q <= '0;
    end else begin
      st_q   <= st_d;
      miss_q <= miss_d;
    end
  end
endmodule

// File: rtl/fa_ais_insert.sv
module fa_ais_insert #(
  parameter int A1_CNT = 12,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 11
) (
  input  logic             ais_on,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [7:0]       din,
  output logic [7:0]       dout
);
  import fa_pkg::*;

  logic [7:0] fill;

  always_comb begin
    fill = AIS_VAL;
    if (row == '0) begin
      if (col < COL_W'(A1_CNT))          fill = A1_VAL;
      else if (col < COL_W'(2 * A1_CNT)) fill = A2_VAL;
    end
    dout = ais_on ? fill : din;
  end
endmodule

// File: rtl/oc12_frame_aligner.sv
module oc12_frame_aligner #(
  parameter int A1_CNT     = 12,
  parameter int PAT_HALF   = 3,
  parameter int ROW_BYTES  = 1080,
  parameter int ROWS       = 9,
  parameter int MISS_LIMIT = 4,
  parameter int ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1,
  parameter int COL_W      = $clog2(ROW_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             ais_dis,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_sof,
  output logic [ROW_W-1:0] out_row,
  output logic [COL_W-1:0] out_col,
  output logic             oof
);
  localparam int ANCHOR = A1_CNT + PAT_HALF - 1;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             hit;
  logic             load;
  logic             at_anchor;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic [7:0]       mux_byte;

  fa_pattern_det #(.HALF(PAT_HALF)) u_det (
    .clk(clk), .rst_n(rst_int_n), .en(in_valid), .din(in_byte), .hit(hit)
  );

  fa_pos_counter #(
    .ROWS(ROWS), .COLS(ROW_BYTES), .ANCHOR(ANCHOR), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_pos (
    .clk(clk), .rst_n(rst_int_n), .en(in_valid), .load(load),
    .cur_row(cur_row), .cur_col(cur_col), .at_anchor(at_anchor)
  );

  fa_sync_fsm #(.MISS_LIMIT(MISS_LIMIT)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .en(in_valid), .hit(hit),
    .at_anchor(at_anchor), .load(load), .oof(oof)
  );

  fa_ais_insert #(.A1_CNT(A1_CNT), .ROW_W(ROW_W), .COL_W(COL_W)) u_ais (
    .ais_on(oof & ~ais_dis), .row(cur_row), .col(cur_col),
    .din(in_byte), .dout(mux_byte)
  );

  logic             vld_d;
  logic [7:0]       byte_d;
  logic             sof_d;
  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;

  always_comb begin
    vld_d  = in_valid;
    byte_d = out_byte;
    sof_d  = out_sof;
    row_d  = out_row;
    col_d  = out_col;
    if (in_valid) begin
      byte_d = mux_byte;
      sof_d  = (cur_row == '0) && (cur_col == '0);
      row_d  = cur_row;
      col_d  = cur_col;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_sof   <= 1'b0;
      out_row   <= '0;
      out_col   <= '0;
    end else begin
      out_valid <= vld_d;
      out_byte  <= byte_d;
      out_sof   <= sof_d & vld_d;
      out_row   <= row_d;
      out_col   <= col_d;
    end
  end
endmodule

// File: rtl/fa_aligner_chk.sv
module fa_aligner_chk #(
  parameter int A1_CNT   = 12,
  parameter int PAT_HALF = 3,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             ais_dis,
  input logic             out_valid,
  input logic [7:0]       out_byte,
  input logic             out_sof,
  input logic [ROW_W-1:0] out_row,
  input logic [COL_W-1:0] out_col,
  input logic             oof
);
  localparam int ANCHOR = A1_CNT + PAT_HALF - 1;

  AST_SOF_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (out_valid && out_row == '0 && out_col == '0)); // R9

  AST_VALID_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R10

  AST_IDLE_HOLDS_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_row) && $stable(out_col))); // R10

  AST_FILL_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && oof && !ais_dis && out_row != '0) |-> (out_byte == 8'hFF)); // R5

  AST_LOSS_AT_ANCHOR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oof) |-> (out_row == '0 && out_col == COL_W'(ANCHOR))); // R4

  AST_LOCK_AT_ANCHOR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oof) |-> (out_row == '0 && out_col == COL_W'(ANCHOR))); // R3
endmodule

bind oc12_frame_aligner fa_aligner_chk #(
  .A1_CNT(A1_CNT), .PAT_HALF(PAT_HALF), .ROW_W(ROW_W), .COL_W(COL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ais_dis(ais_dis),
  .out_valid(out_valid), .out_byte(out_byte), .out_sof(out_sof),
  .out_row(out_row), .out_col(out_col), .oof(oof)
);

// File: tb/oc12_frame_aligner_tb.sv
module oc12_frame_aligner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int A1N   = 4;
  localparam int HALF  = 3;
  localparam int COLS  = 32;
  localparam int ROWS  = 3;
  localparam int FRAME = COLS * ROWS;
  localparam int MC    = A1N + HALF - 1;
  localparam int RW    = $clog2(ROWS);
  localparam int CW    = $clog2(COLS);

  localparam int K_GOOD  = 0;
  localparam int K_BAD   = 1;
  localparam int K_STRAY = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [7:0]    in_byte;
  logic          ais_dis;
  logic          out_valid;
  logic [7:0]    out_byte;
  logic          out_sof;
  logic [RW-1:0] out_row;
  logic [CW-1:0] out_col;
  logic          oof;

  int checks = 0;
  int errs   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oc12_frame_aligner #(
    .A1_CNT(A1N), .PAT_HALF(HALF), .ROW_BYTES(COLS), .ROWS(ROWS), .MISS_LIMIT(4)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .ais_dis(ais_dis), .out_valid(out_valid), .out_byte(out_byte),
    .out_sof(out_sof), .out_row(out_row), .out_col(out_col), .oof(oof)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int kind, input int r, input int c);
    if (r == 0 && c < A1N) return 8'hF6;
    if (r == 0 && c < 2*A1N) begin
      if (kind == K_BAD && c == A1N + 1) return 8'h00;
      return 8'h28;
    end
    if (kind == K_STRAY && r == 1 && c >= 10 && c < 13) return 8'hF6;
    if (kind == K_STRAY && r == 1 && c >= 13 && c < 16) return 8'h28;
    return 8'((r * 37 + c * 11 + 5) & 8'hFF);
  endfunction

  // entered and left on a falling edge
  task automatic send_byte(input logic [7:0] b);
    in_byte  = b;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle_cycle();
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  // mode: 0 none, 1 pass-through, 2 alarm header, 3 position only
  task automatic send_frame(input int kind, input int len, input int exp_oof,
                            input int mode, input bit gap, input string tag);
    for (int idx = 0; idx < len; idx++) begin
      int r = idx / COLS;
      int c = idx % COLS;
      logic [7:0] b = fbyte(kind, r, c);
      send_byte(b);
      if (r == 0 && c == MC) begin
        chk(oof == exp_oof[0], tag, oof, exp_oof);
        if (mode != 0)
          chk(out_row == 0 && out_col == MC, "R2", out_col, MC);
      end
      if (mode == 1 && r == 0 && c == 0)
        chk(out_sof && out_byte == b, "R9", out_byte, b);
      if (mode == 1 && r == 1 && c == 3) begin
        chk(out_valid && out_byte == b, "R7", out_byte, b);
        chk(out_row == 1 && out_col == 3 && !out_sof, "R9", out_col, 3);
      end
      if (mode == 2 && r == 0 && c == 0)
        chk(out_sof && out_byte == 8'hF6, "R5", out_byte, 8'hF6);
      if (mode == 2 && r == 0 && c == A1N)
        chk(out_byte == 8'h28, "R5", out_byte, 8'h28);
      if (gap && r == 1 && c == 3) begin
        for (int g = 0; g < 3; g++) idle_cycle();
        chk(!out_valid, "R10", out_valid, 0);
      end
      if (gap && r == 1 && c == 4)
        chk(out_valid && out_row == 1 && out_col == 4, "R10", out_col, 4);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; ais_dis = 1'b0;
    repeat (3) @(negedge clk);
    chk(oof && !out_valid && !out_sof, "R1", {oof, out_valid, out_sof}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(oof && !out_valid && !out_sof, "R1", {oof, out_valid, out_sof}, 3'b100);
  endtask

  task automatic t_acquire();
    // counter starts at row 0 col 0 while hunting
    send_byte(8'h55);
    chk(out_byte == 8'hF6 && oof, "R5", out_byte, 8'hF6);
    for (int i = 1; i < 20; i++) send_byte(8'h55);
    chk(out_byte == 8'hFF, "R5", out_byte, 8'hFF);
    send_frame(K_GOOD, FRAME, 1, 3, 1'b0, "R3");
    send_frame(K_GOOD, FRAME, 0, 2, 1'b0, "R3");
  endtask

  task automatic t_in_frame();
    send_frame(K_GOOD, FRAME, 0, 1, 1'b0, "R7");
    send_frame(K_GOOD, FRAME, 0, 1, 1'b1, "R10");
  endtask

  task automatic t_loss();
    for (int i = 0; i < 3; i++) send_frame(K_BAD, FRAME, 0, 0, 1'b0, "R4");
    send_frame(K_GOOD, FRAME, 0, 1, 1'b0, "R4");
    for (int i = 0; i < 3; i++) send_frame(K_BAD, FRAME, 0, 0, 1'b0, "R4");
    send_frame(K_BAD, FRAME, 1, 3, 1'b0, "R4");
    send_frame(K_GOOD, FRAME, 1, 3, 1'b0, "R3");
    send_frame(K_GOOD, FRAME, 0, 1, 1'b0, "R3");
  endtask

  task automatic t_stray();
    send_frame(K_STRAY, FRAME, 0, 1, 1'b0, "R4");
    send_frame(K_GOOD, FRAME, 0, 1, 1'b0, "R4");
  endtask

  task automatic t_restart();
    for (int i = 0; i < 3; i++) send_frame(K_BAD, FRAME, 0, 0, 1'b0, "R4");
    send_frame(K_BAD, FRAME, 1, 0, 1'b0, "R4");
    // enter confirmation, then cut the frame short so the next word is early
    send_frame(K_GOOD, FRAME - 10, 1, 3, 1'b0, "R8");
    send_frame(K_GOOD, FRAME, 1, 3, 1'b0, "R8");
    send_frame(K_GOOD, FRAME, 0, 1, 1'b0, "R8");
  endtask

  task automatic t_disable();
    ais_dis = 1'b1;
    for (int i = 0; i < 3; i++) send_frame(K_BAD, FRAME, 0, 0, 1'b0, "R4");
    send_frame(K_BAD, FRAME, 1, 0, 1'b0, "R6");
    send_frame(K_GOOD, FRAME, 1, 1, 1'b0, "R6");
    chk(oof, "R6", oof, 1);
    ais_dis = 1'b0;
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_in_frame();
    t_loss();
    t_stray();
    t_restart();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule